// File: doc/BRIEF.md
# Sub-Word Addressable Register File

This block is a bank of eight 32-bit general-purpose registers with two combinational read ports and one clocked write port. Each port names a register and picks how much of it to touch: the whole 32-bit word, the lower 16-bit half, or one of the two bytes that make up that lower half. All of these views share the same storage. A narrow write changes only the bits it names, and a narrow read returns those bits right-aligned with zeros above them.

Only the first four registers (indices 0 to 3) can be used a byte at a time. The other four (indices 4 to 7) offer the full word and the lower half only. Each port decodes its index, size code and byte select. It raises an error output when the combination is not allowed. A write that is not allowed changes nothing.

The block is meant to sit behind an instruction decoder that has already worked out the operand registers and widths. The error outputs give that decoder a way to trap encodings that are not allowed.

Top module: `subword_regfile`

## Requirements
- R1: Once reset has been applied, every register reads as 0x00000000.
- R2: Size code 2'b00 selects the full word. A legal word write replaces all 32 bits of the addressed register, and no write changes any register other than the addressed one.
- R3: Size code 2'b01 selects bits 15:0. A half write loads wr_data[15:0] into bits 15:0 and leaves bits 31:16 unchanged.
- R4: Size code 2'b10 selects a byte, and only registers 0 to 3 accept it. The byte select chooses bits 15:8 when 1 and bits 7:0 when 0. A byte write loads wr_data[7:0] into the chosen byte and leaves the other 24 bits unchanged.
- R5: A write is rejected in two cases: size code 2'b11 to any register, or size code 2'b10 to registers 4 to 7. For a rejected write, wr_err is high in the same cycle while wr_en is high, and no register changes.
- R6: A legal narrow read returns its bits at the bottom of the read data, with zeros above them. A half read gives bits 15:0. A byte read with the select at 1 gives bits 15:8, and with the select at 0 gives bits 7:0.
- R7: A read port raises its error output and drives zero data under two conditions: a size code of 2'b11, or a byte size code on registers 4 to 7.
- R8: A read of the register being written in the same cycle returns the value from before the write. The new value is visible from the next cycle.
- R9: The two read ports work independently of each other. Each one returns its own register and view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and releases synchronously |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Index of the register to write |
| wr_size | input | 2 | Write size code: 00 word, 01 half, 10 byte, 11 reserved |
| wr_hi | input | 1 | Byte select for byte writes (1 = bits 15:8) |
| wr_data | input | 32 | Write data. Byte writes use bits 7:0 |
| wr_err | output | 1 | The write request is not allowed |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 byte select |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | The read port 0 access is not allowed |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 byte select |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | The read port 1 access is not allowed |

## Verification
The hardest case to reach is a narrow write landing on top of a register whose other bits already hold distinctive non-zero values, followed by a read that shows those bits survived. A write and a read of the same register in the same cycle is just as hard to hit. Directed steps first fill a register with a full-word pattern. They then write its high byte, its low byte and its half, and read the whole word back after each write. The random phase draws index, size and byte select for all three ports from a small space, so that collisions between ports, reserved size codes and byte views of the upper four registers come up often. A bench model follows every legal write.

// File: rtl/subword_rf_pkg.sv
package subword_rf_pkg;

  // Size code presented on every port
  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Decoded view of a register
  typedef enum logic [1:0] {
    VIEW_FULL = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_BLO  = 2'b10,
    VIEW_BHI  = 2'b11
  } view_e;

  typedef struct packed {
    logic  legal;
    view_e view;
  } acc_dec_t;

endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rf_acc_decode.sv
module rf_acc_decode
  import subword_rf_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             hi,
  output acc_dec_t         dec
);

  logic byte_ok;

  assign byte_ok = (32'(idx) < NUM_BYTE_REGS);

  always_comb begin
    dec.legal = 1'b0;
    dec.view  = VIEW_FULL;
    unique case (acc_size_e'(size))
      SZ_WORD: begin
        dec.legal = 1'b1;
        dec.view  = VIEW_FULL;
      end
      SZ_HALF: begin
        dec.legal = 1'b1;
        dec.view  = VIEW_HALF;
      end
      SZ_BYTE: begin
        dec.legal = byte_ok;
        dec.view  = hi ? VIEW_BHI : VIEW_BLO;
      end
      default: begin
        dec.legal = 1'b0;
        dec.view  = VIEW_FULL;
      end
    endcase
  end

endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import subword_rf_pkg::*;
#(
  parameter int DATA_W     = 32,
  localparam int LANES     = DATA_W / 8,
  localparam int HALF_LANES = LANES / 2
) (
  input  acc_dec_t          dec,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wd
);

  always_comb begin
    be = '0;
    wd = din;
    if (dec.legal) begin
      unique case (dec.view)
        VIEW_FULL: be = '1;
        VIEW_HALF: be[HALF_LANES-1:0] = '1;
        VIEW_BLO:  be[0] = 1'b1;
        VIEW_BHI: begin
          be[1]     = 1'b1;
          wd[8 +: 8] = din[7:0];
        end
        default: be = '0;
      endcase
    end
  end

endmodule

// File: rtl/rf_read_view.sv
module rf_read_view
  import subword_rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  acc_dec_t          dec,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] dout
);

  always_comb begin
    dout = '0;
    if (dec.legal) begin
      unique case (dec.view)
        VIEW_FULL: dout = word;
        VIEW_HALF: dout[HALF_W-1:0] = word[HALF_W-1:0];
        VIEW_BLO:  dout[7:0] = word[7:0];
        VIEW_BHI:  dout[7:0] = word[15:8];
        default:   dout = '0;
      endcase
    end
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int LANES   = DATA_W / 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 widx,
  input  logic [LANES-1:0]                 be,
  input  logic [DATA_W-1:0]                wd,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic              reg_en;
    logic [DATA_W-1:0] reg_nxt;

    assign reg_en = we && (widx == IDX_W'(i));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign reg_nxt[l*8 +: 8] = be[l] ? wd[l*8 +: 8] : q[i][l*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (reg_en) begin
        q[i] <= reg_nxt;
      end
    end

    // R2: a register not addressed by a write keeps its value
    p_idle_reg_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (widx == IDX_W'(i))) |=> $stable(q[i]));
  end

  // R1: registers are clear when reset is released
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0));

endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
  import subword_rf_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  parameter int DATA_W        = 32,
  localparam int IDX_W        = $clog2(NUM_REGS),
  localparam int LANES        = DATA_W / 8,
  localparam int HALF_W       = DATA_W / 2,
  localparam int NUM_RD       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  input  logic              rd0_hi,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_err,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  input  logic              rd1_hi,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_err
);

  logic                            rst_sync_n;
  acc_dec_t                        wr_dec;
  logic [LANES-1:0]                wr_be;
  logic [DATA_W-1:0]               wr_wd;
  logic                            wr_go;
  logic [NUM_REGS-1:0][DATA_W-1:0] q_all;

  logic [IDX_W-1:0]  rd_idx_a  [NUM_RD];
  logic [1:0]        rd_size_a [NUM_RD];
  logic              rd_hi_a   [NUM_RD];
  logic [DATA_W-1:0] rd_data_a [NUM_RD];
  logic              rd_err_a  [NUM_RD];

  rf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write path
  rf_acc_decode #(.NUM_REGS(NUM_REGS), .NUM_BYTE_REGS(NUM_BYTE_REGS)) u_wr_dec (
    .idx  (wr_idx),
    .size (wr_size),
    .hi   (wr_hi),
    .dec  (wr_dec)
  );

  rf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .dec  (wr_dec),
    .din  (wr_data),
    .be   (wr_be),
    .wd   (wr_wd)
  );

  assign wr_go  = wr_en && wr_dec.legal;
  assign wr_err = wr_en && !wr_dec.legal;

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_go),
    .widx  (wr_idx),
    .be    (wr_be),
    .wd    (wr_wd),
    .q     (q_all)
  );

  // Read ports
  assign rd_idx_a[0]  = rd0_idx;
  assign rd_size_a[0] = rd0_size;
  assign rd_hi_a[0]   = rd0_hi;
  assign rd_idx_a[1]  = rd1_idx;
  assign rd_size_a[1] = rd1_size;
  assign rd_hi_a[1]   = rd1_hi;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    acc_dec_t rd_dec;

    rf_acc_decode #(.NUM_REGS(NUM_REGS), .NUM_BYTE_REGS(NUM_BYTE_REGS)) u_dec (
      .idx  (rd_idx_a[p]),
      .size (rd_size_a[p]),
      .hi   (rd_hi_a[p]),
      .dec  (rd_dec)
    );

    rf_read_view #(.DATA_W(DATA_W)) u_view (
      .dec  (rd_dec),
      .word (q_all[rd_idx_a[p]]),
      .dout (rd_data_a[p])
    );

    assign rd_err_a[p] = !rd_dec.legal;

    // R6: a half read carries nothing above bit 15
    p_half_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_size_a[p] == SZ_HALF) |-> (rd_data_a[p][DATA_W-1:HALF_W] == '0));

    // R6: a byte read carries nothing above bit 7
    p_byte_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_size_a[p] == SZ_BYTE) |-> (rd_data_a[p][DATA_W-1:8] == '0));

    // R7: a rejected read returns zero
    p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      rd_err_a[p] |-> (rd_data_a[p] == '0));
  end

  assign rd0_data = rd_data_a[0];
  assign rd0_err  = rd_err_a[0];
  assign rd1_data = rd_data_a[1];
  assign rd1_err  = rd_err_a[1];

  // R5: a rejected write leaves every register as it was
  p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_err |=> (q_all == $past(q_all)));

  // R3: a half write keeps the upper half
  p_half_keeps_upper_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_err && wr_size == SZ_HALF) |=>
      (q_all[$past(wr_idx)][DATA_W-1:HALF_W] == $past(q_all[wr_idx][DATA_W-1:HALF_W])));

  // R3: a half write loads the lower half
  p_half_loads_lower_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_err && wr_size == SZ_HALF) |=>
      (q_all[$past(wr_idx)][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

  // R4: a byte write keeps bits 31:16
  p_byte_keeps_upper_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_err && wr_size == SZ_BYTE) |=>
      (q_all[$past(wr_idx)][DATA_W-1:HALF_W] == $past(q_all[wr_idx][DATA_W-1:HALF_W])));

endmodule

// File: tb/test_subword_regfile.sv
module test_subword_regfile;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  rd0_idx;
  logic [1:0]  rd0_size;
  logic        rd0_hi;
  logic [31:0] rd0_data;
  logic        rd0_err;
  logic [2:0]  rd1_idx;
  logic [1:0]  rd1_size;
  logic        rd1_hi;
  logic [31:0] rd1_data;
  logic        rd1_err;

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;
  logic [31:0] model [8];
  logic [31:0] got0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_regfile i_subword_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .wr_err   (wr_err),
    .rd0_idx  (rd0_idx),
    .rd0_size (rd0_size),
    .rd0_hi   (rd0_hi),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err),
    .rd1_idx  (rd1_idx),
    .rd1_size (rd1_size),
    .rd1_hi   (rd1_hi),
    .rd1_data (rd1_data),
    .rd1_err  (rd1_err)
  );

  function automatic logic legal(input logic [2:0] idx, input logic [1:0] s);
    return (s != 2'b11) && !(s == 2'b10 && idx >= 3'd4);
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic [1:0] s,
                                           input logic h);
    logic [31:0] r = model[idx];
    if (!legal(idx, s)) return 32'h0;
    case (s)
      2'b00:   return r;
      2'b01:   return {16'h0, r[15:0]};
      default: return h ? {24'h0, r[15:8]} : {24'h0, r[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] s,
                                        input logic h, input logic [31:0] d);
    case (s)
      2'b00:   return d;
      2'b01:   return {old[31:16], d[15:0]};
      default: return h ? {old[31:16], d[7:0], old[7:0]} : {old[31:8], d[7:0]};
    endcase
  endfunction

  function automatic string rd_tag(input int port, input logic [2:0] idx, input logic [1:0] s,
                                   input logic wlegal, input logic [2:0] widx);
    if (!legal(idx, s)) return "R7";
    if (wlegal && widx == idx) return "R8";
    if (s != 2'b00) return "R6";
    return (port == 1) ? "R9" : "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wi, input logic [1:0] ws,
                      input logic wh, input logic [31:0] wd,
                      input logic [2:0] i0, input logic [1:0] s0, input logic h0,
                      input logic [2:0] i1, input logic [1:0] s1, input logic h1);
    logic wl;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_hi = wh; wr_data = wd;
    rd0_idx = i0; rd0_size = s0; rd0_hi = h0;
    rd1_idx = i1; rd1_size = s1; rd1_hi = h1;
    wl = we && legal(wi, ws);
    #1;
    got0 = rd0_data;
    chk(rd_tag(0, i0, s0, wl, wi), rd0_data, exp_read(i0, s0, h0));
    chk("R7", {31'h0, rd0_err}, {31'h0, !legal(i0, s0)});
    chk(rd_tag(1, i1, s1, wl, wi), rd1_data, exp_read(i1, s1, h1));
    chk("R7", {31'h0, rd1_err}, {31'h0, !legal(i1, s1)});
    chk("R5", {31'h0, wr_err}, {31'h0, we && !legal(wi, ws)});
    @(posedge clk);
    if (wl) model[wi] = merge(model[wi], ws, wh, wd);
  endtask

  task automatic wr(input logic [2:0] wi, input logic [1:0] ws, input logic wh,
                    input logic [31:0] wd);
    step(1'b1, wi, ws, wh, wd, wi, 2'b00, 1'b0, 3'd0, 2'b00, 1'b0);
  endtask

  task automatic peek(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    step(1'b0, 3'd0, 2'b00, 1'b0, 32'h0, idx, 2'b00, 1'b0, idx, 2'b01, 1'b0);
    chk(tag, got0, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_0042;
    int unsigned r;
    r = $urandom(seed);
    for (int k = 0; k < 8; k++) model[k] = 32'h0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
    rd0_idx = '0; rd0_size = '0; rd0_hi = 1'b0;
    rd1_idx = '0; rd1_size = '0; rd1_hi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: all registers clear after reset
    for (int k = 0; k < 8; k++) peek(3'(k), 32'h0, "R1");

    // R2: full word write
    wr(3'd5, 2'b00, 1'b0, 32'hDEADBEEF);
    peek(3'd5, 32'hDEADBEEF, "R2");
    // R3: half write keeps upper half
    wr(3'd5, 2'b01, 1'b0, 32'hFFFF1234);
    peek(3'd5, 32'hDEAD1234, "R3");
    // R4: high byte then low byte of register 2
    wr(3'd2, 2'b00, 1'b0, 32'h11223344);
    wr(3'd2, 2'b10, 1'b1, 32'hFFFFFFAB);
    peek(3'd2, 32'h1122AB44, "R4");
    wr(3'd2, 2'b10, 1'b0, 32'h000000CD);
    peek(3'd2, 32'h1122ABCD, "R4");
    // R6: narrow reads of register 2
    step(1'b0, 3'd0, 2'b00, 1'b0, 32'h0, 3'd2, 2'b10, 1'b1, 3'd2, 2'b01, 1'b0);
    chk("R6", got0, 32'h000000AB);
    // R5: byte write to register 6 and reserved size to register 1 are rejected
    wr(3'd6, 2'b10, 1'b0, 32'h00000077);
    peek(3'd6, 32'h0, "R5");
    wr(3'd1, 2'b11, 1'b0, 32'h12345678);
    peek(3'd1, 32'h0, "R5");
    // R7: rejected reads
    step(1'b0, 3'd0, 2'b00, 1'b0, 32'h0, 3'd7, 2'b10, 1'b0, 3'd5, 2'b11, 1'b0);
    // R8: read of the register being written returns the old value
    step(1'b1, 3'd5, 2'b00, 1'b0, 32'hCAFEF00D, 3'd5, 2'b00, 1'b0, 3'd5, 2'b01, 1'b0);
    chk("R8", got0, 32'hDEAD1234);
    peek(3'd5, 32'hCAFEF00D, "R8");

    // Random phase: R2 to R9
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      step(a[0] | a[1], a[4:2], a[6:5], a[7], b,
           a[10:8], a[12:11], a[13], a[16:14], a[18:17], a[19]);
    end
    for (int k = 0; k < 8; k++) peek(3'(k), model[k], "R2");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule